// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Control

This block decides where each operand of a five-stage in-order integer pipeline comes from. It keeps a compact copy of the hazard-relevant fields of the three later pipeline registers: source and destination specifiers, whether each source is read, and the write, load and store controls. The instruction waiting in decode feeds this copy. The block compares the sources of the instruction in execute against the destinations of the two older instructions that have not yet written back. From that comparison it drives the select lines and the outputs of the two ALU operand multiplexers. It also drives the store-data multiplexer for the instruction in the memory stage.

When a load sits in execute and the instruction in decode reads the loaded register in its ALU, the block raises a stall for exactly one cycle. The surrounding pipeline holds the program counter and the decode register while stall is high. The block itself turns its execute-stage entry into a bubble by clearing that entry's control bits. On the next cycle the loaded value is bypassed from the write-back stage. The register file, the ALU and the memories stay outside. They appear only as the data values the multiplexers choose between.

Top module: `hz_ctrl`

## Requirements
- R1: While reset is active and right after reset is released, `stall` is 0, all three selects are 0, and each data output equals its register-file or pass-through input.
- R2: The decode-stage sources are taken only from `id_instr[25:21]` (operand A) and `id_instr[20:16]` (operand B). No other instruction bits change any output.
- R3: Select encoding: 0 = register file or pass-through, 1 = EX/MEM ALU result, 2 = MEM/WB ALU result, 3 = MEM/WB load data. An executing operand whose source equals the destination of a writing, non-load instruction one stage ahead selects 1.
- R4: An operand whose source equals the destination of a writing instruction two stages ahead selects 2 when that instruction is not a load and 3 when it is.
- R5: When both older stages match the same source, the EX/MEM result (select 1) wins.
- R6: Register 0 never causes a non-zero select and never causes a stall.
- R7: A source field that the instruction does not read gives select 0 and causes no stall. Operand B of a store counts as read for bypassing but not for stalling.
- R8: A load in execute whose destination is read by the ALU of the instruction in decode raises `stall` for exactly one cycle. The entry that enters execute next carries no write, load or store control, so it never becomes a bypass source.
- R9: After that one stall, the consumer receives the load result with select 3. Consumers two or more instructions behind the load see no stall.
- R10: For a store in the memory stage whose B source equals the destination of a writing instruction in write-back, the store select is 2 (ALU) or 3 (load). Otherwise it is 0 and `st_data` equals `exmem_b`.
- R11: A load directly followed by a store that uses the loaded register only as store data causes no stall, and the store select becomes 3 one cycle later.
- R12: `op_a`, `op_b` and `st_data` always equal the data input named by their select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_instr | input | 32 | Instruction word held in decode |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_use_a | input | 1 | Decode instruction reads source A in its ALU |
| id_use_b | input | 1 | Decode instruction reads source B in its ALU |
| id_wr | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_store | input | 1 | Decode instruction is a store (B is store data) |
| rf_a | input | 32 | Register-file value A of the executing instruction |
| rf_b | input | 32 | Register-file value B of the executing instruction |
| exmem_alu | input | 32 | ALU result held in EX/MEM |
| memwb_alu | input | 32 | ALU result held in MEM/WB |
| memwb_ld | input | 32 | Load data held in MEM/WB |
| exmem_b | input | 32 | Store data latched in EX/MEM |
| stall | output | 1 | Hold PC and decode; bubble enters execute |
| fwd_a_sel | output | 2 | Operand A select |
| fwd_b_sel | output | 2 | Operand B select |
| st_sel | output | 2 | Store-data select |
| op_a | output | 32 | Chosen operand A |
| op_b | output | 32 | Chosen operand B |
| st_data | output | 32 | Chosen store data |

## Verification
The dependent chain add-sub-and-or-xor separates bypassing from EX/MEM from bypassing from MEM/WB and from the register file, with zero stall cycles. The chain lw-sub-and-or must cost exactly one stall cycle and then show load-data bypass. Directed pairs cover the remaining corners: a double match for priority, register 0, a field that is not read, and a load feeding a store. Each of them tells a correct gating apart from a missing or inverted one. Seeded random programs on a four-register pool make matches and load-use pairs frequent, and every cycle is compared with a bench reference model.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int REG_W = 5;

  typedef enum logic [1:0] {
    SEL_RF     = 2'd0,
    SEL_EXMEM  = 2'd1,
    SEL_WB_ALU = 2'd2,
    SEL_WB_LD  = 2'd3
  } fwd_sel_e;

  // hazard-relevant view of one pipeline register
  typedef struct packed {
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
    logic             use_a;
    logic             use_b;
    logic             wr;
    logic             ld;
    logic             st;
  } stage_t;

  // a writer of a non-zero register equal to the source
  function automatic logic dst_hit(input logic wr,
                                   input logic [REG_W-1:0] dst,
                                   input logic [REG_W-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

  // operand source choice: younger stage first, loads never from younger
  function automatic fwd_sel_e pick_sel(input logic need,
                                        input logic [REG_W-1:0] src,
                                        input stage_t yng,
                                        input stage_t old);
    if (!need) return SEL_RF;
    if (dst_hit(yng.wr && !yng.ld, yng.dst, src)) return SEL_EXMEM;
    if (dst_hit(old.wr, old.dst, src)) return old.ld ? SEL_WB_LD : SEL_WB_ALU;
    return SEL_RF;
  endfunction

  // load in execute feeding an ALU read of the decode instruction
  function automatic logic load_use(input stage_t ex,
                                    input logic use_a, input logic [REG_W-1:0] a,
                                    input logic use_b, input logic [REG_W-1:0] b);
    return ex.ld && ((use_a && dst_hit(ex.wr, ex.dst, a)) ||
                     (use_b && dst_hit(ex.wr, ex.dst, b)));
  endfunction

endpackage

// File: rtl/hz_stage_regs.sv
module hz_stage_regs
  import hz_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stall_i,
  input  stage_t fetched_i,
  output stage_t idex_o,
  output stage_t exmem_o,
  output stage_t memwb_o
);

  stage_t bubble;

  // bubble keeps specifier fields, drops every control bit
  always_comb begin
    bubble       = fetched_i;
    bubble.use_a = 1'b0;
    bubble.use_b = 1'b0;
    bubble.wr    = 1'b0;
    bubble.ld    = 1'b0;
    bubble.st    = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_o  <= '0;
      exmem_o <= '0;
      memwb_o <= '0;
    end else begin
      memwb_o <= exmem_o;
      exmem_o <= idex_o;
      idex_o  <= stall_i ? bubble : fetched_i;
    end
  end

  AST_BUBBLE_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> (!idex_o.wr && !idex_o.ld && !idex_o.st)); // R8

endmodule

// File: rtl/hz_op_fwd.sv
module hz_op_fwd
  import hz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             need_i,
  input  logic [REG_W-1:0] src_i,
  input  stage_t           yng_i,
  input  stage_t           old_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  yng_alu_i,
  input  logic [XLEN-1:0]  old_alu_i,
  input  logic [XLEN-1:0]  old_ld_i,
  output fwd_sel_e         sel_o,
  output logic [XLEN-1:0]  val_o
);

  assign sel_o = pick_sel(need_i, src_i, yng_i, old_i);

  always_comb begin
    unique case (sel_o)
      SEL_EXMEM:  val_o = yng_alu_i;
      SEL_WB_ALU: val_o = old_alu_i;
      SEL_WB_LD:  val_o = old_ld_i;
      default:    val_o = base_i;
    endcase
  end

endmodule

// File: rtl/hz_load_lock.sv
module hz_load_lock
  import hz_pkg::*;
(
  input  stage_t           ex_i,
  input  logic             use_a_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic             use_b_i,
  input  logic [REG_W-1:0] src_b_i,
  output logic             stall_o
);

  assign stall_o = load_use(ex_i, use_a_i, src_a_i, use_b_i, src_b_i);

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] id_instr,
  input  logic [4:0]      id_rd,
  input  logic            id_use_a,
  input  logic            id_use_b,
  input  logic            id_wr,
  input  logic            id_load,
  input  logic            id_store,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] exmem_alu,
  input  logic [XLEN-1:0] memwb_alu,
  input  logic [XLEN-1:0] memwb_ld,
  input  logic [XLEN-1:0] exmem_b,
  output logic            stall,
  output logic [1:0]      fwd_a_sel,
  output logic [1:0]      fwd_b_sel,
  output logic [1:0]      st_sel,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] st_data
);

  // fixed source fields, counted from the top of the word
  localparam int A_HI   = XLEN - 1 - 6;
  localparam int B_HI   = XLEN - 1 - 11;
  localparam int LANES  = 3;        // ALU A, ALU B, store data
  localparam int LANE_W = $clog2(LANES);

  stage_t fetched, idex, exmem, memwb;
  logic   unused_bits;

  assign unused_bits = ^{id_instr[XLEN-1:A_HI+1], id_instr[B_HI-REG_W:0]};

  always_comb begin
    fetched.src_a = id_instr[A_HI -: REG_W];
    fetched.src_b = id_instr[B_HI -: REG_W];
    fetched.dst   = id_rd;
    fetched.use_a = id_use_a;
    fetched.use_b = id_use_b;
    fetched.wr    = id_wr;
    fetched.ld    = id_load;
    fetched.st    = id_store;
  end

  hz_load_lock i_lock (
    .ex_i    (idex),
    .use_a_i (fetched.use_a),
    .src_a_i (fetched.src_a),
    .use_b_i (fetched.use_b),
    .src_b_i (fetched.src_b),
    .stall_o (stall)
  );

  hz_stage_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_i   (stall),
    .fetched_i (fetched),
    .idex_o    (idex),
    .exmem_o   (exmem),
    .memwb_o   (memwb)
  );

  // per-lane inputs: store lane has no younger stage to draw from
  logic             lane_need [LANES];
  logic [REG_W-1:0] lane_src  [LANES];
  stage_t           lane_yng  [LANES];
  logic [XLEN-1:0]  lane_base [LANES];
  logic [XLEN-1:0]  lane_yalu [LANES];
  fwd_sel_e         lane_sel  [LANES];
  logic [XLEN-1:0]  lane_val  [LANES];

  always_comb begin
    lane_need[0] = idex.use_a;
    lane_src[0]  = idex.src_a;
    lane_yng[0]  = exmem;
    lane_base[0] = rf_a;
    lane_yalu[0] = exmem_alu;
    lane_need[1] = idex.use_b || idex.st;
    lane_src[1]  = idex.src_b;
    lane_yng[1]  = exmem;
    lane_base[1] = rf_b;
    lane_yalu[1] = exmem_alu;
    lane_need[2] = exmem.st;
    lane_src[2]  = exmem.src_b;
    lane_yng[2]  = '0;
    lane_base[2] = exmem_b;
    lane_yalu[2] = '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hz_op_fwd #(.XLEN(XLEN)) i_fwd (
      .need_i    (lane_need[g]),
      .src_i     (lane_src[g]),
      .yng_i     (lane_yng[g]),
      .old_i     (memwb),
      .base_i    (lane_base[g]),
      .yng_alu_i (lane_yalu[g]),
      .old_alu_i (memwb_alu),
      .old_ld_i  (memwb_ld),
      .sel_o     (lane_sel[g]),
      .val_o     (lane_val[g])
    );
  end

  assign fwd_a_sel = lane_sel[LANE_W'(0)];
  assign fwd_b_sel = lane_sel[LANE_W'(1)];
  assign st_sel    = lane_sel[LANE_W'(2)];
  assign op_a      = lane_val[LANE_W'(0)];
  assign op_b      = lane_val[LANE_W'(1)];
  assign st_data   = lane_val[LANE_W'(2)];

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R8

  AST_NO_LOAD_IN_EXMEM_USE: assert property (@(posedge clk) disable iff (!rst_n)
    !(exmem.ld && ((idex.use_a && dst_hit(exmem.wr, exmem.dst, idex.src_a)) ||
                   (idex.use_b && dst_hit(exmem.wr, exmem.dst, idex.src_b))))); // R9

  AST_R0_SILENT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'd0) |-> (idex.src_a != '0)); // R6

  AST_R0_SILENT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b_sel != 2'd0) |-> (idex.src_b != '0)); // R6

  AST_STORE_SEL_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_sel != 2'd0) |-> exmem.st); // R10

  AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (idex.use_a && dst_hit(exmem.wr && !exmem.ld, exmem.dst, idex.src_a))
      |-> (fwd_a_sel == 2'd1)); // R5

endmodule

// File: tb/test_hz_ctrl.sv
module test_hz_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_instr = '0;
  logic [4:0]  id_rd = '0;
  logic        id_use_a = 0, id_use_b = 0, id_wr = 0, id_load = 0, id_store = 0;
  logic [31:0] rf_a = '0, rf_b = '0, exmem_alu = '0, memwb_alu = '0, memwb_ld = '0, exmem_b = '0;
  logic        stall;
  logic [1:0]  fwd_a_sel, fwd_b_sel, st_sel;
  logic [31:0] op_a, op_b, st_data;

  always #2 clk = ~clk;

  hz_ctrl i_hz_ctrl (.*);

  typedef struct {
    logic [4:0] ra, rb, rd;
    bit ua, ub, wr, ld, st;
  } ins_t;

  int   n_chk = 0, n_bad = 0;
  ins_t prog [$];
  ins_t m_ex, m_mem, m_wb;

  function automatic ins_t nop();
    ins_t r = '{default: '0};
    return r;
  endfunction
  function automatic ins_t alu(int d, int a, int b);
    ins_t r = nop(); r.rd = 5'(d); r.ra = 5'(a); r.rb = 5'(b);
    r.ua = 1; r.ub = 1; r.wr = 1; return r;
  endfunction
  function automatic ins_t imm(int d, int a, int junk_b);
    ins_t r = alu(d, a, junk_b); r.ub = 0; return r;
  endfunction
  function automatic ins_t lw(int d, int a);
    ins_t r = imm(d, a, 0); r.ld = 1; return r;
  endfunction
  function automatic ins_t sw(int a, int b);
    ins_t r = nop(); r.ra = 5'(a); r.rb = 5'(b); r.ua = 1; r.st = 1; return r;
  endfunction

  function automatic int exp_sel(bit need, logic [4:0] s, ins_t y, ins_t o);
    if (!need || s == 0) return 0;
    if (y.wr && !y.ld && y.rd == s) return 1;
    if (o.wr && o.rd == s) return o.ld ? 3 : 2;
    return 0;
  endfunction

  function automatic logic [31:0] exp_val(int sel, logic [31:0] base);
    case (sel)
      1: return exmem_alu;
      2: return memwb_alu;
      3: return memwb_ld;
      default: return base;
    endcase
  endfunction

  function automatic string why(int sel, bit need, logic [4:0] s);
    if (sel == 1) return "R3";
    if (sel == 2) return "R4";
    if (sel == 3) return "R9";
    if (!need) return "R7";
    return (s == 0) ? "R6" : "R3";
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_prog(string tag, int exp_stalls);
    int pc = 0, stalls = 0;
    prog.push_back(nop()); prog.push_back(nop()); prog.push_back(nop());
    while (pc < prog.size()) begin
      ins_t cur = prog[pc];
      bit   st_exp;
      int   sa, sb, ss;
      id_instr = {6'($urandom), cur.ra, cur.rb, 16'($urandom)};
      id_rd = cur.rd; id_use_a = cur.ua; id_use_b = cur.ub;
      id_wr = cur.wr; id_load = cur.ld; id_store = cur.st;
      rf_a = $urandom; rf_b = $urandom; exmem_alu = $urandom;
      memwb_alu = $urandom; memwb_ld = $urandom; exmem_b = $urandom;
      #1;
      st_exp = m_ex.ld && m_ex.wr && m_ex.rd != 0 &&
               ((cur.ua && cur.ra == m_ex.rd) || (cur.ub && cur.rb == m_ex.rd));
      sa = exp_sel(m_ex.ua, m_ex.ra, m_mem, m_wb);
      sb = exp_sel(m_ex.ub || m_ex.st, m_ex.rb, m_mem, m_wb);
      ss = exp_sel(m_mem.st, m_mem.rb, nop(), m_wb);
      chk(stall == st_exp, {tag, " R8 stall"}, stall, st_exp);
      chk(fwd_a_sel == 2'(sa), {tag, " ", why(sa, m_ex.ua, m_ex.ra), " sel A"}, fwd_a_sel, sa);
      chk(fwd_b_sel == 2'(sb), {tag, " ", why(sb, m_ex.ub || m_ex.st, m_ex.rb), " sel B"}, fwd_b_sel, sb);
      chk(st_sel == 2'(ss), {tag, " R10 store sel"}, st_sel, ss);
      chk(op_a == exp_val(sa, rf_a), {tag, " R12 op_a"}, op_a, exp_val(sa, rf_a));
      chk(op_b == exp_val(sb, rf_b), {tag, " R12 op_b"}, op_b, exp_val(sb, rf_b));
      chk(st_data == exp_val(ss, exmem_b), {tag, " R12 st_data"}, st_data, exp_val(ss, exmem_b));
      if (stall) stalls++;
      @(posedge clk);
      m_wb = m_mem; m_mem = m_ex;
      if (st_exp) begin
        m_ex = cur; m_ex.ua = 0; m_ex.ub = 0; m_ex.wr = 0; m_ex.ld = 0; m_ex.st = 0;
      end else begin
        m_ex = cur; pc++;
      end
      @(negedge clk);
    end
    if (exp_stalls >= 0) chk(stalls == exp_stalls, {tag, " R8 stall count"}, stalls, exp_stalls);
    prog.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ex = nop(); m_mem = nop(); m_wb = nop();
    rf_a = 32'h1111_0001; rf_b = 32'h2222_0002; exmem_b = 32'h3333_0003;
    repeat (3) @(negedge clk);
    #1;
    chk(stall == 0 && fwd_a_sel == 0 && fwd_b_sel == 0 && st_sel == 0, "R1 reset selects",
        {stall, fwd_a_sel, fwd_b_sel, st_sel}, 0);
    chk(op_a == rf_a && op_b == rf_b && st_data == exmem_b, "R1 reset data", op_a, rf_a);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(stall == 0 && fwd_a_sel == 0 && st_sel == 0, "R1 after release", stall, 0);
    @(negedge clk);

    // add-sub-and-or-xor on r1: EX/MEM, MEM/WB, then register file
    prog = '{alu(1,2,3), alu(4,1,5), alu(6,1,7), alu(8,1,9), alu(10,1,11)};
    run_prog("R3 R4 chain", 0);
    // lw-sub-and-or: one stall, then load data bypass
    prog = '{lw(1,2), alu(4,1,6), alu(6,1,7), alu(8,1,9)};
    run_prog("R9 load-use", 1);
    // double match on r1: younger wins
    prog = '{alu(1,2,3), alu(1,4,5), alu(7,1,1)};
    run_prog("R5 priority", 0);
    // register 0 never bypasses nor stalls
    prog = '{lw(0,2), alu(4,0,0), alu(0,3,3), alu(5,0,6)};
    run_prog("R6 zero reg", 0);
    // unread field B equal to load destination: no stall
    prog = '{lw(3,2), imm(4,5,3), imm(6,7,3)};
    run_prog("R7 immediate", 0);
    // load then store of loaded data: no stall, store select 3
    prog = '{lw(3,2), sw(5,3), alu(4,6,7), sw(8,4)};
    run_prog("R11 load-store", 0);
    // random bits outside the fields: only field matches count
    prog = '{alu(1,2,3), alu(4,5,6), alu(7,8,9)};
    run_prog("R2 fields", 0);

    for (int p = 0; p < 60; p++) begin
      for (int k = 0; k < 12; k++) begin
        int t = $urandom_range(0, 4);
        int d = $urandom_range(0, 3), a = $urandom_range(0, 3), b = $urandom_range(0, 3);
        case (t)
          0: prog.push_back(lw(d, a));
          1: prog.push_back(sw(a, b));
          2: prog.push_back(imm(d, a, b));
          3: prog.push_back(nop());
          default: prog.push_back(alu(d, a, b));
        endcase
      end
      run_prog("R3 random", -1);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule